// File: doc/BRIEF.md
# Core Tick Timer with Control/Status Register

This block is a free-running 8-bit timer for a small processor subsystem. A prescaler divides the bus clock by `PRE_DIV`, and each prescaled tick advances an 8-bit counter. A further chain of divider stages sits above the counter, and four of its stages can serve as the periodic-interrupt tick. A two-bit rate field picks which stage is used. Each stage has twice the period of the one below it. The selected tick goes out on `rti_tick` as a one-cycle pulse, so that a watchdog divider can count it.

Software uses one byte-wide control/status register at bus address `REG_ADDR`, which is 0x08 by default. The register holds a wrap flag, a periodic flag, an interrupt enable for each flag, and the rate field. Hardware sets the flags. Software clears a flag by writing 0 to its bit. The `irq` output goes high while a flag and its enable bit are both set.

Top module: `core_tick_timer`

## Requirements
- R1: After reset the register reads 0x03: both flags 0, both enables 0 and rate field 11. The counter reads 0 and `irq` is 0.
- R2: `tmr_count` advances by one every `PRE_DIV` bus clocks. It wraps from 0xFF to 0x00 and otherwise never changes.
- R3: Bit 7, the wrap flag, is set in the same cycle that `tmr_count` wraps from 0xFF to 0x00.
- R4: Bits 1:0 select the periodic tick. Its period is `PRE_DIV`·2^(8+`RTI_FIRST`+sel) bus clocks, which is 2048·2^sel with the default parameters. On each tick, bit 6 (the periodic flag) is set and `rti_tick` pulses high for exactly one cycle.
- R5: Writing 0 to bit 7 or bit 6 clears that flag. Writing 1 to it leaves the flag unchanged. No other event clears a flag.
- R6: Bits 5 (wrap interrupt enable), 4 (periodic interrupt enable) and 1:0 take the written value. Bits 3:2 always read 0, and writes to them are ignored.
- R7: `irq` is high one cycle after (bit7 AND bit5) OR (bit6 AND bit4) is true, and it is low otherwise.
- R8: If hardware sets a flag in the same cycle that software writes 0 to it, the flag ends that cycle set.
- R9: A read (`bus_cs`=1, `bus_we`=0, `bus_addr`=`REG_ADDR`) returns the register contents on `bus_rdata` one cycle later. In every other cycle `bus_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Access address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tmr_count | output | CNT_W | Current timer counter value |
| rti_tick | output | 1 | One-cycle pulse on each selected periodic tick |
| irq | output | 1 | Registered interrupt request |

## Verification
A wrong prescaler or counter state shows up on `tmr_count` within `PRE_DIV` cycles. It shifts the wrap flag by a whole count period, up to 1024 cycles with the default parameters. A wrong tap decode or rate field only shows when `rti_tick` and bit 6 fire at the wrong time, and that can take up to 16384 cycles at the slowest rate. A lost or stuck flag or enable bit shows on `irq` one cycle later, and it shows on the next register read.

// File: rtl/core_tick_pkg.sv
package core_tick_pkg;
  localparam int CSR_W    = 8;
  localparam int SEL_W    = 2;
  localparam int BIT_OVF  = 7;
  localparam int BIT_RTI  = 6;
  localparam int BIT_OEN  = 5;
  localparam int BIT_REN  = 4;
  localparam logic [SEL_W-1:0] SEL_RESET = 2'b11;

  typedef struct packed {
    logic             ovf_flag;
    logic             rti_flag;
    logic             ovf_en;
    logic             rti_en;
    logic [1:0]       zero_pad;
    logic [SEL_W-1:0] rate_sel;
  } csr_t;
endpackage

// File: rtl/ctm_prescaler.sv
module ctm_prescaler #(
  parameter int PRE_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic step
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst)          pre_q <= '0;
    else if (step)    pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

  assign step = (pre_q == LAST);
endmodule

// File: rtl/ctm_divchain.sv
module ctm_divchain #(
  parameter int CNT_W     = 8,
  parameter int RTI_FIRST = 1,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] count,
  output logic             ovf_evt,
  output logic             rti_evt
);
  localparam int N_TAPS  = 1 << SEL_W;
  localparam int CHAIN_W = CNT_W + RTI_FIRST + N_TAPS - 1;

  logic [CHAIN_W-1:0] chain_q;
  logic [N_TAPS-1:0]  tap_full;

  always_ff @(posedge clk) begin
    if (rst)       chain_q <= '0;
    else if (step) chain_q <= chain_q + 1'b1;
  end

  for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
    assign tap_full[k] = &chain_q[CNT_W+RTI_FIRST+k-1:0];
  end

  assign count   = chain_q[CNT_W-1:0];
  assign ovf_evt = step & (&chain_q[CNT_W-1:0]);
  assign rti_evt = step & tap_full[sel];
endmodule

// File: rtl/ctm_csr.sv
module ctm_csr
  import core_tick_pkg::*;
#(
  parameter int               ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h08
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CSR_W-1:0]  bus_wdata,
  input  logic              ovf_evt,
  input  logic              rti_evt,
  output logic [CSR_W-1:0]  bus_rdata,
  output logic              ovf_flag,
  output logic              rti_flag,
  output logic              ovf_en,
  output logic              rti_en,
  output logic [SEL_W-1:0]  rate_sel,
  output logic              irq
);
  logic hit, wr_go, rd_go;
  logic unused_pad;
  csr_t view;

  assign hit        = bus_cs && (bus_addr == REG_ADDR);
  assign wr_go      = hit && bus_we;
  assign rd_go      = hit && !bus_we;
  assign unused_pad = ^bus_wdata[3:2];

  always_comb begin
    view          = '0;
    view.ovf_flag = ovf_flag;
    view.rti_flag = rti_flag;
    view.ovf_en   = ovf_en;
    view.rti_en   = rti_en;
    view.rate_sel = rate_sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag  <= 1'b0;
      rti_flag  <= 1'b0;
      ovf_en    <= 1'b0;
      rti_en    <= 1'b0;
      rate_sel  <= SEL_RESET;
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (ovf_evt)                          ovf_flag <= 1'b1;
      else if (wr_go && !bus_wdata[BIT_OVF]) ovf_flag <= 1'b0;
      if (rti_evt)                          rti_flag <= 1'b1;
      else if (wr_go && !bus_wdata[BIT_RTI]) rti_flag <= 1'b0;
      if (wr_go) begin
        ovf_en   <= bus_wdata[BIT_OEN];
        rti_en   <= bus_wdata[BIT_REN];
        rate_sel <= bus_wdata[SEL_W-1:0];
      end
      bus_rdata <= rd_go ? CSR_W'(view) : '0;
      irq       <= (ovf_flag && ovf_en) || (rti_flag && rti_en);
    end
  end
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
  import core_tick_pkg::*;
#(
  parameter int               PRE_DIV   = 4,
  parameter int               CNT_W     = 8,
  parameter int               RTI_FIRST = 1,
  parameter int               ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h08
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [CNT_W-1:0]  tmr_count,
  output logic              rti_tick,
  output logic              irq
);
  logic             step, ovf_evt, rti_evt;
  logic             ovf_flag, rti_flag, ovf_en, rti_en;
  logic [SEL_W-1:0] rate_sel;

  ctm_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst(rst), .step(step)
  );

  ctm_divchain #(.CNT_W(CNT_W), .RTI_FIRST(RTI_FIRST), .SEL_W(SEL_W)) u_div (
    .clk(clk), .rst(rst), .step(step), .sel(rate_sel),
    .count(tmr_count), .ovf_evt(ovf_evt), .rti_evt(rti_evt)
  );

  ctm_csr #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_csr (
    .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ovf_evt(ovf_evt), .rti_evt(rti_evt), .bus_rdata(bus_rdata),
    .ovf_flag(ovf_flag), .rti_flag(rti_flag), .ovf_en(ovf_en),
    .rti_en(rti_en), .rate_sel(rate_sel), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) rti_tick <= 1'b0;
    else     rti_tick <= rti_evt;
  end
endmodule

// File: rtl/ctm_checker.sv
module ctm_checker #(
  parameter int               CNT_W    = 8,
  parameter int               ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h08
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_cs,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [CNT_W-1:0]  tmr_count,
  input logic              rti_tick,
  input logic              irq,
  input logic              ovf_flag,
  input logic              rti_flag,
  input logic              ovf_en,
  input logic              rti_en
);
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && tmr_count != $past(tmr_count)) |-> tmr_count == CNT_W'($past(tmr_count) + 1'b1));

  p_ovf_set_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tmr_count) == '1 && tmr_count == '0) |-> ovf_flag);

  p_rti_flag_r4: assert property (@(posedge clk) disable iff (rst)
    rti_tick |-> rti_flag);

  p_tick_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rti_tick |=> !rti_tick);

  p_flag_hold_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf_flag) |-> $past(bus_cs && bus_we && bus_addr == REG_ADDR && !bus_wdata[7]));

  p_rsv_zero_r6: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[3:2] == 2'b00);

  p_irq_r7: assert property (@(posedge clk) disable iff (rst)
    irq == $past((ovf_flag && ovf_en) || (rti_flag && rti_en)));

  p_rd_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_cs) |-> bus_rdata == 8'h00);
endmodule

bind core_tick_timer ctm_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_count(tmr_count),
  .rti_tick(rti_tick), .irq(irq), .ovf_flag(ovf_flag), .rti_flag(rti_flag),
  .ovf_en(ovf_en), .rti_en(rti_en)
);

// File: tb/test_core_tick_timer.sv
`timescale 1ns/1ps
module test_core_tick_timer;
  localparam int PRE_DIV   = 4;
  localparam int RTI_FIRST = 1;
  localparam logic [7:0] RA = 8'h08;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_cs = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata, tmr_count;
  logic rti_tick, irq;

  int total = 0, bad = 0, cyc = 0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  core_tick_timer #(.PRE_DIV(PRE_DIV), .RTI_FIRST(RTI_FIRST), .REG_ADDR(RA)) i_core_tick_timer (
    .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_count(tmr_count),
    .rti_tick(rti_tick), .irq(irq)
  );

  // reference model built from the requirements
  int m_pre;
  logic [11:0] m_chain;
  logic m_ovf, m_rti, m_oen, m_ren, m_irq, m_tick;
  logic [1:0] m_sel;
  logic [7:0] m_rd;

  function automatic logic [7:0] m_csr();
    return {m_ovf, m_rti, m_oen, m_ren, 2'b00, m_sel};
  endfunction

  function automatic bit m_tap_hit(logic [11:0] ch, logic [1:0] s);
    int n = 8 + RTI_FIRST + int'(s);
    logic [11:0] msk = 12'((1 << n) - 1);
    return (ch & msk) == msk;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pre = 0; m_chain = '0; m_ovf = 0; m_rti = 0; m_oen = 0; m_ren = 0;
      m_sel = 2'b11; m_rd = '0; m_irq = 0; m_tick = 0;
    end else begin
      bit pt, oe, re, wr;
      pt = (m_pre == PRE_DIV - 1);
      oe = pt && (m_chain[7:0] == 8'hFF);
      re = pt && m_tap_hit(m_chain, m_sel);
      wr = bus_cs && bus_we && bus_addr == RA;
      m_rd   = (bus_cs && !bus_we && bus_addr == RA) ? m_csr() : 8'h00;
      m_irq  = (m_ovf && m_oen) || (m_rti && m_ren);
      m_tick = re;
      if (oe) m_ovf = 1; else if (wr && !bus_wdata[7]) m_ovf = 0;
      if (re) m_rti = 1; else if (wr && !bus_wdata[6]) m_rti = 0;
      if (wr) begin m_oen = bus_wdata[5]; m_ren = bus_wdata[4]; m_sel = bus_wdata[1:0]; end
      m_pre = pt ? 0 : m_pre + 1;
      if (pt) m_chain = m_chain + 1'b1;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && cmp_on) begin
      check(tmr_count == m_chain[7:0], "R2 counter", tmr_count, m_chain[7:0]);
      check(rti_tick == m_tick, "R4 rti_tick", rti_tick, m_tick);
      check(irq == m_irq, "R7 irq", irq, m_irq);
      check(bus_rdata == m_rd, "R9 read data", bus_rdata, m_rd);
      check(bus_rdata[7] == m_rd[7], "R3 wrap flag bit", bus_rdata[7], m_rd[7]);
      check(bus_rdata[6] == m_rd[6], "R4 periodic flag bit", bus_rdata[6], m_rd[6]);
      check(bus_rdata[3:2] == 2'b00, "R6 pad bits", bus_rdata[3:2], 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<200000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_cs = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 0; bus_we = 0;
  endtask

  task automatic rd(output logic [7:0] d);
    bus_cs = 1; bus_we = 0; bus_addr = RA;
    @(negedge clk);
    bus_cs = 0;
    d = bus_rdata;
  endtask

  initial begin
    logic [7:0] v;
    int gap;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 0;
    cmp_on = 1;
    @(negedge clk);
    check(tmr_count == 0 && irq == 0, "R1 counter/irq after reset", {tmr_count, irq}, 0);
    rd(v);
    check(v == 8'h03, "R1 reset value", v, 8'h03);

    wr(RA, 8'h30);
    // R8: clear of the wrap flag lands on the wrap cycle
    while (!(m_pre == PRE_DIV - 1 && m_chain[7:0] == 8'hFF)) @(negedge clk);
    wr(RA, 8'h70);
    rd(v);
    check(v[7] == 1'b1, "R8 set wins over clear", v[7], 1);
    check(v[7] == 1'b1, "R3 wrap flag set", v[7], 1);
    wr(RA, 8'hF0);
    rd(v);
    check(v[7] == 1'b1, "R5 write 1 keeps flag", v[7], 1);
    @(negedge clk);
    check(irq == 1'b1, "R7 irq with wrap flag and enable", irq, 1);
    wr(RA, 8'h70);
    rd(v);
    check(v[7] == 1'b0, "R5 write 0 clears flag", v[7], 0);
    wr(RA, 8'hFE);
    rd(v);
    check((v & 8'h3F) == 8'h32, "R6 written fields, pad ignored", v & 8'h3F, 8'h32);

    // R4: tick spacing at rate 0
    wr(RA, 8'hF0);
    gap = 0;
    while (!rti_tick && gap < 5000) begin @(negedge clk); gap++; end
    @(negedge clk);
    gap = 1;
    while (!rti_tick && gap < 5000) begin @(negedge clk); gap++; end
    check(gap == 2048, "R4 tick period at rate 0", gap, 2048);

    // constrained random phase
    for (int i = 0; i < 30000; i++) begin
      int r = int'($urandom_range(0, 63));
      if (r == 0) begin
        logic [7:0] d = 8'($urandom);
        if ($urandom_range(0, 3) != 0) d[7:6] = 2'b11;
        wr(($urandom_range(0, 7) == 0) ? 8'($urandom) : RA, d);
      end else if (r < 16) begin
        bus_cs = 1; bus_we = 0;
        bus_addr = ($urandom_range(0, 3) == 0) ? 8'($urandom) : RA;
        @(negedge clk);
        bus_cs = 0;
      end else begin
        @(negedge clk);
      end
    end

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule